// File: doc/BRIEF.md
# Constant-Weight Symbol Encoder

This block turns binary data words into n-bit line symbols in which exactly m bits are set. A link that drives its wires with such symbols always steers current through the same number of lines. Its common node therefore stays at a fixed voltage whatever the data. The widths N and M are parameters, with defaults of 8 wires and 4 ones. Under those defaults there are 70 legal symbols. Each symbol carries a 6-bit data word, and the 6 codes that data never uses serve as control symbols for idle, framing or error marking.

The block does not look codes up in a stored table. A symbol's rank is its position in ascending numeric order among all N-bit words of weight M. The block turns a rank into a symbol with a chain of N small stages, one per wire, starting from the most significant. Each stage compares the remaining rank with a binomial coefficient and subtracts it when the rank is large enough. Data value k uses rank k. Control index j uses rank 2^DATA_W + j. Control index 0 is the idle symbol, which the output register also holds after reset.

The upstream side offers a word with a valid flag. A control request flag with an index selects a control symbol in place of data. The encoded symbol appears one clock after the word is accepted.

Top module: `cw_encoder`

## Requirements
- R1: Every value on `sym_out`, from reset onward, has exactly M bits at 1 (4 of 8 by default).
- R2: An accepted data word k (with `req_ctrl` low) gives the k-th weight-M word in ascending numeric order, counting from 0. For example, k=0 gives 8'h0F by default.
- R3: The data width is floor(log2(C(N,M))), which is 6 bits by default. All 2^DATA_W data symbols and all C(N,M)−2^DATA_W control symbols (6 by default) are distinct.
- R4: An accepted word with `req_ctrl` high and `ctrl_idx` j below the control count gives the weight-M word of rank 2^DATA_W + j. In that case `word_in` has no effect on the result.
- R5: A control request whose `ctrl_idx` is at or above the control count (6 and 7 by default) gives the idle symbol, which is rank 2^DATA_W (8'hD8 by default).
- R6: While `rst_n` is low at a clock edge, `sym_out` becomes the idle symbol, `sym_valid` becomes 0 and `in_ready` becomes 0. From the first edge with `rst_n` high onward, `in_ready` is 1.
- R7: A word is accepted at an edge where both `in_valid` and `in_ready` are 1. Its symbol appears on `sym_out` after that edge, and `sym_valid` is 1 for exactly the cycles that follow an acceptance.
- R8: At an edge with no acceptance, `sym_out` keeps its previous value and `sym_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream offers a word this cycle |
| in_ready | output | 1 | Block accepts a word this cycle |
| req_ctrl | input | 1 | 1 selects a control symbol instead of data |
| ctrl_idx | input | CTRL_W (3) | Control symbol index; out-of-range values give idle |
| word_in | input | DATA_W (6) | Data word to encode |
| sym_valid | output | 1 | A new symbol was loaded at the last edge |
| sym_out | output | N (8) | Registered constant-weight symbol |

## Verification
The assertions assume that `in_valid`, `req_ctrl`, `ctrl_idx` and `word_in` are stable and known at each rising edge while `rst_n` is high. The rank-range check also relies on the control clamp having kept every rank below C(N,M). The stimulus meets these assumptions by changing inputs only on the falling edge and by driving only 0 or 1, never X. Every data word and every control index, including the out-of-range ones, is sent at least once. Random traffic with idle gaps and mixed data and control requests follows.

// File: rtl/cw_pkg.sv
// Package cw_pkg
// Constant functions shared by the encoder: binomial coefficient, floor log2
// and a reference rank-to-symbol conversion used only to derive constants.
// Assumes N stays small enough that C(N,M) fits in 63 bits.
package cw_pkg;

    // Binomial coefficient C(n,k); zero when k > n.
    function automatic longint binom(input int n, input int k);
        longint r;
        if (k < 0 || k > n) return 64'd0;
        r = 1;
        for (int i = 0; i < k; i++) r = r * longint'(n - i) / longint'(i + 1);
        return r;
    endfunction

    // Largest b with 2**b <= v, for v >= 1.
    function automatic int flog2(input longint v);
        int b;
        b = 0;
        while ((v >> (b + 1)) != 0) b++;
        return b;
    endfunction

    // Greedy unranking used to build constants such as the idle symbol.
    function automatic logic [63:0] unrank_const(input int n, input int m, input longint rank);
        logic [63:0] w;
        longint rem;
        int k;
        w = '0; rem = rank; k = m;
        for (int p = n - 1; p >= 0; p--) begin
            if (k > 0 && rem >= binom(p, k)) begin
                w[p] = 1'b1;
                rem  = rem - binom(p, k);
                k    = k - 1;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/cw_rank_sel.sv
// Module cw_rank_sel
// Chooses the rank to encode: the data word itself, or 2**DATA_W plus the
// control index. Control indices at or beyond the number of spare codes
// are clamped to the idle rank (first control code). Purely combinational.
module cw_rank_sel #(
    parameter int DATA_W   = 6,
    parameter int CTRL_W   = 3,
    parameter int NUM_CTRL = 6,
    parameter int RW       = 7
) (
    input  logic              req_ctrl,
    input  logic [CTRL_W-1:0] ctrl_idx,
    input  logic [DATA_W-1:0] word_in,
    output logic [RW-1:0]     rank
);
    localparam int NUM_DATA = 1 << DATA_W;

    // Map request to rank, clamping unknown control indices to idle.
    always_comb begin
        if (!req_ctrl)
            rank = RW'(word_in);
        else if (int'(ctrl_idx) < NUM_CTRL)
            rank = RW'(NUM_DATA + int'(ctrl_idx));
        else
            rank = RW'(NUM_DATA);
    end
endmodule

// File: rtl/cw_unrank_stage.sv
// Module cw_unrank_stage
// One wire of the unranking chain. Given the remaining rank and the number of
// ones still to place, it sets its wire when the rank is at least C(POS,k)
// and passes on the reduced rank and count. Assumes rem_i < C(POS+1,k_i).
module cw_unrank_stage
    import cw_pkg::*;
#(
    parameter int POS = 0,
    parameter int M   = 4,
    parameter int RW  = 7,
    parameter int KW  = 3
) (
    input  logic [RW-1:0] rem_i,
    input  logic [KW-1:0] k_i,
    output logic [RW-1:0] rem_o,
    output logic [KW-1:0] k_o,
    output logic          bit_o
);
    logic [RW-1:0] coef;
    logic          take;

    // Pick the binomial coefficient C(POS,k_i) from constants.
    always_comb begin
        coef = '0;
        for (int j = 0; j <= M; j++)
            if (int'(k_i) == j) coef = RW'(binom(POS, j));
    end

    // Decide this wire and pass on the remainder.
    always_comb begin
        take  = (k_i != '0) && (rem_i >= coef);
        bit_o = take;
        rem_o = take ? (rem_i - coef) : rem_i;
        k_o   = take ? (k_i - KW'(1)) : k_i;
    end
endmodule

// File: rtl/cw_encoder.sv
// Module cw_encoder
// Constant-weight encoder: each accepted word becomes an N-bit symbol with
// exactly M ones, registered one cycle after acceptance. Spare codes beyond
// 2**DATA_W are control symbols; control 0 is idle and is the reset value.
// Assumes M is N/2 rounded, so the code space is the largest for N.
module cw_encoder
    import cw_pkg::*;
#(
    parameter int N = 8,
    parameter int M = 4,
    localparam int TOTAL    = int'(binom(N, M)),
    localparam int DATA_W   = flog2(longint'(TOTAL)),
    localparam int NUM_DATA = 1 << DATA_W,
    localparam int NUM_CTRL = TOTAL - NUM_DATA,
    localparam int CTRL_W   = (NUM_CTRL > 2) ? $clog2(NUM_CTRL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              req_ctrl,
    input  logic [CTRL_W-1:0] ctrl_idx,
    input  logic [DATA_W-1:0] word_in,
    output logic              sym_valid,
    output logic [N-1:0]      sym_out
);
    localparam int RW = (TOTAL > 2) ? $clog2(TOTAL) : 1;
    localparam int KW = $clog2(M + 1);
    localparam logic [N-1:0] IDLE_SYM = N'(unrank_const(N, M, longint'(NUM_DATA)));

    logic [RW-1:0] rank;
    logic [RW-1:0] rem_chain [0:N];
    logic [KW-1:0] k_chain   [0:N];
    logic [N-1:0]  sym_next;
    logic          accept;

    cw_rank_sel #(
        .DATA_W  (DATA_W),
        .CTRL_W  (CTRL_W),
        .NUM_CTRL(NUM_CTRL),
        .RW      (RW)
    ) u_sel (
        .req_ctrl(req_ctrl),
        .ctrl_idx(ctrl_idx),
        .word_in (word_in),
        .rank    (rank)
    );

    assign rem_chain[0] = rank;
    assign k_chain[0]   = KW'(M);

    // One stage per wire, most significant wire first.
    for (genvar s = 0; s < N; s++) begin : g_stage
        cw_unrank_stage #(
            .POS(N - 1 - s),
            .M  (M),
            .RW (RW),
            .KW (KW)
        ) u_stage (
            .rem_i(rem_chain[s]),
            .k_i  (k_chain[s]),
            .rem_o(rem_chain[s+1]),
            .k_o  (k_chain[s+1]),
            .bit_o(sym_next[N-1-s])
        );
    end

    assign accept = in_valid && in_ready;

    // Ready rises on the first edge out of reset and stays up.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Load the symbol on acceptance, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_out   <= IDLE_SYM;
            sym_valid <= 1'b0;
        end else begin
            sym_valid <= accept;
            if (accept) sym_out <= sym_next;
        end
    end

    AST_RANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rank) < TOTAL);                                                 // R5
    AST_CHAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        k_chain[N] == '0);                                                   // R1
    AST_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sym_out) == M);                                           // R1
    AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> sym_valid);                                               // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(sym_out) && !sym_valid));                       // R8
    AST_CLAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_ctrl && int'(ctrl_idx) >= NUM_CTRL) |=> sym_out == IDLE_SYM); // R5
    AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> in_ready);                                                  // R6
endmodule

// File: tb/cw_encoder_test.sv
// Bench for cw_encoder at default parameters (N=8, M=4, 6 data bits,
// 6 control codes). Inputs change on the falling edge; outputs are sampled
// on the following falling edge, one rising edge after being driven.
module cw_encoder_test;
    localparam int N = 8;
    localparam int M = 4;
    localparam int DW = 6;
    localparam int CW = 3;
    localparam int NDATA = 64;
    localparam int NCTRL = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          req_ctrl = 1'b0;
    logic [CW-1:0] ctrl_idx = '0;
    logic [DW-1:0] word_in = '0;
    logic          sym_valid;
    logic [N-1:0]  sym_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [N-1:0] exp_q;
    logic [N-1:0] seen [0:NDATA+NCTRL-1];

    always #2 clk = ~clk;

    cw_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .req_ctrl(req_ctrl), .ctrl_idx(ctrl_idx), .word_in(word_in),
        .sym_valid(sym_valid), .sym_out(sym_out)
    );

    // Rank r symbol: the r-th N-bit value (from 0) with M ones, by scanning.
    function automatic logic [N-1:0] ref_sym(input int r);
        int cnt;
        cnt = 0;
        for (int v = 0; v < (1 << N); v++) begin
            if ($countones(v[N-1:0]) == M) begin
                if (cnt == r) return v[N-1:0];
                cnt++;
            end
        end
        return '0;
    endfunction

    function automatic int ref_rank(input logic c, input int idx, input int d);
        if (!c) return d;
        if (idx < NCTRL) return NDATA + idx;
        return NDATA;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then check at the next falling edge.
    task automatic step(input logic v, input logic c, input int idx, input int d, input string req);
        in_valid = v; req_ctrl = c; ctrl_idx = CW'(idx); word_in = DW'(d);
        @(negedge clk);
        if (v) exp_q = ref_sym(ref_rank(c, idx, d));
        check({req, " sym"}, 32'(sym_out), 32'(exp_q));
        check({req, " valid"}, 32'(sym_valid), 32'(v));
        check("R1 weight", 32'($countones(sym_out)), 32'(M));
    endtask

    initial begin
        logic [N-1:0] held;
        void'($urandom(32'd12345));
        exp_q = ref_sym(NDATA);
        @(negedge clk);
        @(negedge clk);
        // R6 reset state
        check("R6 reset sym", 32'(sym_out), 32'(ref_sym(NDATA)));
        check("R6 reset valid", 32'(sym_valid), 32'd0);
        check("R6 reset ready", 32'(in_ready), 32'd0);
        check("R5 idle is D8", 32'(ref_sym(NDATA)), 32'h0D8);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 ready after reset", 32'(in_ready), 32'd1);
        check("R8 idle after reset", 32'(sym_out), 32'(ref_sym(NDATA)));

        // R2: every data word, kept for the distinctness check
        for (int k = 0; k < NDATA; k++) begin
            step(1'b1, 1'b0, 0, k, "R2 data");
            seen[k] = sym_out;
        end
        check("R2 rank0 is 0F", 32'(ref_sym(0)), 32'h00F);

        // R4: every control index with random data that must have no effect
        for (int j = 0; j < NCTRL; j++) begin
            step(1'b1, 1'b1, j, int'($urandom % 64), "R4 ctrl");
            seen[NDATA+j] = sym_out;
        end

        // R5: out-of-range indices clamp to idle
        step(1'b1, 1'b0, 0, 5, "R7 data before clamp");
        step(1'b1, 1'b1, 6, 33, "R5 clamp idx6");
        check("R5 clamp6 idle", 32'(sym_out), 32'h0D8);
        step(1'b1, 1'b0, 0, 63, "R7 data before clamp");
        step(1'b1, 1'b1, 7, 0, "R5 clamp idx7");
        check("R5 clamp7 idle", 32'(sym_out), 32'h0D8);

        // R3: all symbols distinct
        for (int a = 0; a < NDATA + NCTRL; a++)
            for (int b = a + 1; b < NDATA + NCTRL; b++)
                if (seen[a] == seen[b]) begin
                    fails++;
                    $display("FAIL R3 duplicate actual=%0h expected=distinct (%0d,%0d)", seen[a], a, b);
                end
        checks++;

        // R8: idle cycles hold the symbol, even with changing inputs
        step(1'b1, 1'b0, 0, 17, "R7 load");
        held = sym_out;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, i[0], i, 40 + i, "R8 hold");
            check("R8 held value", 32'(sym_out), 32'(held));
        end

        // Random traffic
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, ($urandom % 4) == 0, int'($urandom % 8),
                 int'($urandom % 64), "R7 random");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule